// File: doc/BRIEF.md
# GPIO Interrupt Source Selector

This block picks, for each of eight parent interrupt lines, one GPIO input out of a wide bank and conditions it for a parent interrupt controller. That controller only understands an active-high level or a rising edge. Each channel has an 8-bit source index and two trigger bits: one chooses level or edge, the other chooses the active sense. A per-channel inverter folds active-low and falling-edge triggers into active-high and rising-edge form, so the parent never needs to know the configured polarity.

Software sets up the channels through a small 32-bit register bus. One register holds the trigger bits, two registers hold the packed source indices, and a filter register is stored and read back but has no effect. A reserved source index detaches a channel, and so does any index past the last implemented input. A channel cannot fire on both edges. Software gets both-edge detection by pointing two channels at the same input and setting one for rising and one for falling.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset the trigger word (offset 0x00) and the filter word (offset 0x0C) read 0, both select words (offsets 0x04 and 0x08) read 0xFFFFFFFF, and every bit of irq_out is low.
- R2: The four words at offsets 0x00, 0x04, 0x08 and 0x0C hold all 32 written bits and read them back unchanged. bus_rdata is combinational on bus_addr, and bus_addr bits [1:0] are ignored, so offset 0x05 reaches the word at 0x04.
- R3: A channel whose select index is 0xFF keeps its irq_out bit low in every trigger mode.
- R4: Channel n takes its source index from bits [8*(n mod 4)+7 : 8*(n mod 4)] of the word at 0x04 (n = 0..3) or 0x08 (n = 4..7). In level mode with high sense (trigger bit n = 0, bit 16+n = 0), irq_out[n] equals the selected input. A change on gpio_in shows on irq_out on the third rising clock edge after it.
- R5: Level mode with low sense (bit n = 0, bit 16+n = 1) drives irq_out[n] high while the selected input is low.
- R6: Edge mode with rising sense (bit n = 1, bit 16+n = 0) produces a pulse of exactly one clock on irq_out[n] for each 0-to-1 transition of the selected input, with the same three-edge latency. The output stays low while the input holds steady.
- R7: Edge mode with falling sense (bit n = 1, bit 16+n = 1) produces a one-clock pulse for each 1-to-0 transition and none for 0-to-1. Every edge-mode pulse lasts a single clock.
- R8: Two channels that select the same input, one set to rising and one to falling, together report both edges of that input, each edge on its own channel.
- R9: A select index at or above NUM_GPIO (other than 0xFF) keeps the channel output low. Index NUM_GPIO-1 is still a valid source.
- R10: Offsets above 0x0C read as 0, and writes to them leave every register and every output unchanged.
- R11: The value in the filter word has no effect on any output or on its latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | NUM_GPIO | Asynchronous GPIO inputs |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_out | output | 8 | Conditioned parent interrupt lines, one per channel |

## Verification
On every cycle, the assertions check three things. A detached or out-of-range channel never drives its output. An edge-mode pulse never lasts beyond one clock. A write above the register window never changes the stored trigger or select fields. The bench scenarios cover everything that depends on a chosen input pattern: the exact three-edge latency, the inversion for low-sense and falling modes, the both-edge channel pair, the last valid index against the first invalid one, the address aliasing, and the fact that the filter word does nothing.

// File: rtl/gir_pkg.sv
package gir_pkg;
    localparam int CH_COUNT   = 8;
    localparam int SEL_W      = 8;
    localparam int DATA_W     = 32;
    localparam int SEL_SPAN   = 1 << SEL_W;
    localparam logic [SEL_W-1:0] SEL_NONE = '1;

    // Word indices (byte offset / 4)
    localparam int WIDX_TRIG  = 0;
    localparam int WIDX_SELLO = 1;
    localparam int WIDX_SELHI = 2;
    localparam int WIDX_FILT  = 3;

    localparam int POL_BASE   = 16;

    typedef struct packed {
        logic [DATA_W-1:0] trig;
        logic [DATA_W-1:0] sel_lo;
        logic [DATA_W-1:0] sel_hi;
        logic [DATA_W-1:0] filt;
    } cfg_regs_t;

    typedef struct packed {
        logic prev;
        logic irq;
    } ch_state_t;
endpackage

// File: rtl/gir_sync.sv
module gir_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = stg_q;
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gir_regs.sv
module gir_regs
    import gir_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    output logic [DATA_W-1:0]                rdata,
    output logic [DATA_W-1:0]                trig,
    output logic [CH_COUNT-1:0][SEL_W-1:0]   ch_sel
);
    localparam int WIDX_W = ADDR_W - 2;

    cfg_regs_t regs_d, regs_q;
    logic [WIDX_W-1:0] widx;
    logic unused_byte_lane;

    assign widx = addr[ADDR_W-1:2];
    assign unused_byte_lane = ^addr[1:0];

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            if (widx == WIDX_W'(WIDX_TRIG))  regs_d.trig   = wdata;
            if (widx == WIDX_W'(WIDX_SELLO)) regs_d.sel_lo = wdata;
            if (widx == WIDX_W'(WIDX_SELHI)) regs_d.sel_hi = wdata;
            if (widx == WIDX_W'(WIDX_FILT))  regs_d.filt   = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.trig   <= '0;
            regs_q.sel_lo <= '1;
            regs_q.sel_hi <= '1;
            regs_q.filt   <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (widx == WIDX_W'(WIDX_TRIG))  rdata = regs_q.trig;
        if (widx == WIDX_W'(WIDX_SELLO)) rdata = regs_q.sel_lo;
        if (widx == WIDX_W'(WIDX_SELHI)) rdata = regs_q.sel_hi;
        if (widx == WIDX_W'(WIDX_FILT))  rdata = regs_q.filt;
    end

    assign trig = regs_q.trig;

    for (genvar i = 0; i < CH_COUNT; i++) begin : g_unpack
        if (i < CH_COUNT / 2) begin : g_lo
            assign ch_sel[i] = regs_q.sel_lo[SEL_W*i +: SEL_W];
        end else begin : g_hi
            assign ch_sel[i] = regs_q.sel_hi[SEL_W*(i-CH_COUNT/2) +: SEL_W];
        end
    end
endmodule

// File: rtl/gir_channel.sv
module gir_channel
    import gir_pkg::*;
#(
    parameter int NUM_GPIO = 140
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GPIO-1:0] gpio_s,
    input  logic [SEL_W-1:0]    sel,
    input  logic                edge_mode,
    input  logic                active_low,
    output logic                irq
);
    ch_state_t st_d, st_q;
    logic [SEL_SPAN-1:0] padded;
    logic hit, cond;

    assign padded = SEL_SPAN'(gpio_s);

    always_comb begin
        hit  = (sel != SEL_NONE) && (32'(sel) < NUM_GPIO);
        // Invert first, then gate, so a detached channel stays quiet in low-sense modes
        cond = hit & (padded[sel] ^ active_low);
        st_d.prev = cond;
        st_d.irq  = edge_mode ? (cond & ~st_q.prev) : cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gir_pkg::*;
#(
    parameter int NUM_GPIO = 140,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GPIO-1:0] gpio_in,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [7:0]          irq_out
);
    logic [NUM_GPIO-1:0]             gpio_s;
    logic [DATA_W-1:0]               trig_q;
    logic [CH_COUNT-1:0][SEL_W-1:0]  ch_sel;

    gir_sync #(.WIDTH(NUM_GPIO), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (gpio_in),
        .dout (gpio_s)
    );

    gir_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .trig  (trig_q),
        .ch_sel(ch_sel)
    );

    for (genvar i = 0; i < CH_COUNT; i++) begin : g_ch
        gir_channel #(.NUM_GPIO(NUM_GPIO)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .gpio_s    (gpio_s),
            .sel       (ch_sel[i]),
            .edge_mode (trig_q[i]),
            .active_low(trig_q[POL_BASE+i]),
            .irq       (irq_out[i])
        );
    end
endmodule

// File: rtl/gir_checker.sv
module gir_checker
    import gir_pkg::*;
#(
    parameter int NUM_GPIO = 140,
    parameter int ADDR_W   = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_wr,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [7:0]                      irq_out,
    input logic [DATA_W-1:0]               trig,
    input logic [CH_COUNT-1:0][SEL_W-1:0]  ch_sel
);
    for (genvar i = 0; i < CH_COUNT; i++) begin : g_chk
        // R3: reserved index keeps output low
        assert_detached_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ch_sel[i]) == SEL_NONE |-> !irq_out[i]);

        // R9: index beyond implemented inputs keeps output low
        assert_range_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            32'($past(ch_sel[i])) >= NUM_GPIO |-> !irq_out[i]);

        // R6 / R7: edge-mode pulse lasts one clock
        assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[i] && trig[i] |=> !irq_out[i]);
    end

    // R10: writes above the register window change nothing
    assert_outer_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr[ADDR_W-1:2] > (ADDR_W-2)'(WIDX_FILT)) |=> $stable(trig) && $stable(ch_sel));
endmodule

bind gpio_irq_router gir_checker #(.NUM_GPIO(NUM_GPIO), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .irq_out (irq_out),
    .trig    (trig_q),
    .ch_sel  (ch_sel)
);

// File: tb/gpio_irq_router_test.sv
module gpio_irq_router_test;
    localparam int NG = 140;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG-1:0] gpio_in = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [7:0]    irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_irq_router #(.NUM_GPIO(NG), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cfg(input logic [31:0] t, input logic [31:0] lo, input logic [31:0] hi);
        wr(8'h00, t); wr(8'h04, lo); wr(8'h08, hi);
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_gpio(input int idx, input logic v);
        @(negedge clk);
        gpio_in[idx] = v;
    endtask

    task automatic lat3();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq_out", {24'h0, irq_out}, 32'h0);
        rd(8'h00, d); chk("R1 trig", d, 32'h0);
        rd(8'h04, d); chk("R1 sel_lo", d, 32'hFFFF_FFFF);
        rd(8'h08, d); chk("R1 sel_hi", d, 32'hFFFF_FFFF);
        rd(8'h0C, d); chk("R1 filt", d, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(8'h0C, 32'h1234_5678); rd(8'h0C, d); chk("R2 filt readback", d, 32'h1234_5678);
        wr(8'h05, 32'hCAFE_F00D); rd(8'h04, d); chk("R2 alias 0x05", d, 32'hCAFE_F00D);
        wr(8'h00, 32'hDEAD_BEEF); rd(8'h03, d); chk("R2 trig readback", d, 32'hDEAD_BEEF);
        cfg(32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h0);
        settle();
    endtask

    task automatic t_level_high();
        cfg(32'h0, 32'hFFFF_FFFF, 32'hFF85_FFFF); // ch6 -> gpio 133
        settle();
        chk("R4 idle low", {24'h0, irq_out}, 32'h0);
        set_gpio(133, 1'b1);
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R4 not yet after two edges", {24'h0, irq_out}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R4 high on third edge", {24'h0, irq_out}, 32'h40);
        set_gpio(133, 1'b0); lat3();
        chk("R4 follows low", {24'h0, irq_out}, 32'h0);
    endtask

    task automatic t_level_low();
        cfg(32'h0002_0000, 32'hFFFF_07FF, 32'hFFFF_FFFF); // ch1 -> gpio 7, low sense
        settle();
        chk("R5 low input asserts", {24'h0, irq_out}, 32'h02);
        set_gpio(7, 1'b1); lat3();
        chk("R5 high input clears", {24'h0, irq_out}, 32'h0);
        set_gpio(7, 1'b0); lat3();
        chk("R5 low again asserts", {24'h0, irq_out}, 32'h02);
    endtask

    task automatic t_edge_rise();
        cfg(32'h0000_0004, 32'hFF0A_FFFF, 32'hFFFF_FFFF); // ch2 -> gpio 10 rising
        settle();
        chk("R6 idle", {24'h0, irq_out}, 32'h0);
        set_gpio(10, 1'b1); lat3();
        chk("R6 pulse", {24'h0, irq_out}, 32'h04);
        @(negedge clk);
        chk("R6 pulse one clock", {24'h0, irq_out}, 32'h0);
        settle();
        chk("R6 steady high quiet", {24'h0, irq_out}, 32'h0);
    endtask

    task automatic t_edge_fall();
        cfg(32'h0004_0004, 32'hFF0A_FFFF, 32'hFFFF_FFFF); // ch2 falling, gpio10 high
        settle();
        chk("R7 idle", {24'h0, irq_out}, 32'h0);
        set_gpio(10, 1'b0); lat3();
        chk("R7 pulse on fall", {24'h0, irq_out}, 32'h04);
        @(negedge clk);
        chk("R7 one clock", {24'h0, irq_out}, 32'h0);
        set_gpio(10, 1'b1); lat3();
        chk("R7 no pulse on rise", {24'h0, irq_out}, 32'h0);
        set_gpio(10, 1'b0); settle();
    endtask

    task automatic t_both();
        cfg(32'h0020_0030, 32'hFFFF_FFFF, 32'hFFFF_1414); // ch4 rise, ch5 fall on gpio 20
        settle();
        chk("R8 idle", {24'h0, irq_out}, 32'h0);
        set_gpio(20, 1'b1); lat3();
        chk("R8 rise on ch4", {24'h0, irq_out}, 32'h10);
        @(negedge clk);
        chk("R8 rise ends", {24'h0, irq_out}, 32'h0);
        set_gpio(20, 1'b0); lat3();
        chk("R8 fall on ch5", {24'h0, irq_out}, 32'h20);
        @(negedge clk);
        chk("R8 fall ends", {24'h0, irq_out}, 32'h0);
    endtask

    task automatic t_detach();
        cfg(32'h00FF_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // all low-sense, all detached
        settle();
        chk("R3 detached low sense", {24'h0, irq_out}, 32'h0);
    endtask

    task automatic t_range();
        cfg(32'h0009_0000, 32'h8CFF_FF8B, 32'hFFFF_FFFF); // ch0 -> 139, ch3 -> 140
        settle();
        chk("R9 last valid vs first invalid", {24'h0, irq_out}, 32'h01);
    endtask

    task automatic t_outer();
        logic [31:0] d;
        cfg(32'h0, 32'hFFFF_FF05, 32'hFFFF_FFFF); // ch0 -> gpio 5
        set_gpio(5, 1'b1); settle();
        wr(8'h10, 32'h0000_FFFF);
        wr(8'hFC, 32'hFFFF_0000);
        rd(8'h10, d); chk("R10 read 0x10", d, 32'h0);
        rd(8'hFC, d); chk("R10 read 0xFC", d, 32'h0);
        rd(8'h00, d); chk("R10 trig kept", d, 32'h0);
        rd(8'h04, d); chk("R10 sel_lo kept", d, 32'hFFFF_FF05);
        settle();
        chk("R10 output kept", {24'h0, irq_out}, 32'h01);
        set_gpio(5, 1'b0); settle();
    endtask

    task automatic t_filter();
        logic [31:0] d;
        wr(8'h0C, 32'hFFFF_FFFF);
        cfg(32'h0, 32'hFFFF_FFFF, 32'hFF85_FFFF);
        settle();
        set_gpio(133, 1'b1);
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R11 no extra delay pre", {24'h0, irq_out}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R11 same latency", {24'h0, irq_out}, 32'h40);
        rd(8'h0C, d); chk("R11 filt stored", d, 32'hFFFF_FFFF);
        set_gpio(133, 1'b0); settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_level_high();
        t_level_low();
        t_edge_rise();
        t_edge_fall();
        t_both();
        t_detach();
        t_range();
        t_outer();
        t_filter();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule